// File: doc/BRIEF.md
# Debug Scan Clock Sequencer

The block is the master side of a debug link to a small target processor. It drives the target's CPU clock and a serial scan port: a scan clock, a data-out line and a data-in line. The scan port feeds a 64-bit chain of shadow registers in the target. Each operation is started with a one-cycle request that carries four enable flags: pre CPU pulse, pre scan pulse, full scan and post CPU pulse. The enabled phases always run in that order and the disabled ones are skipped. This lets software combine "clock the CPU once and snapshot its registers", "scan a vector in and out" and "clock the CPU and then clear the snapshot enable" as it needs.

All pin timing is built from a quarter-period. The quarter-period is given in system clock cycles and is latched when an operation starts. During the full scan, the transmit vector is shifted out most significant bit first, and the bits arriving on the data-in line are assembled into the receive vector in the same order. Two free-running counters record every scan clock pulse and every CPU clock pulse the block has issued since reset.

Top module: `dbg_scan_sequencer`

## Requirements
- R1: Enabled phases run in the fixed order pre CPU pulse, one pre scan clock pulse, full scan (VEC_W scan clock pulses), post CPU pulse. Disabled phases issue no pulses. Flag bit positions: bit 0 pre CPU, bit 1 pre scan, bit 2 full scan, bit 3 post CPU (individual ports in the table).
- R2: Every CPU clock pulse and every scan clock pulse is high for exactly 2·Q system cycles, where Q is the effective quarter-period. A CPU pulse is followed by 2·Q low cycles.
- R3: The post CPU phase issues one CPU clock pulse and then one scan clock pulse. The scan clock pulse follows the CPU pulse's low time.
- R4: The full scan starts with a 2·Q cycle setup slot in which the data-out line carries transmit bit VEC_W-1. After each scan clock falling edge the next lower bit is driven, so a target that samples on rising edges receives the transmit vector MSB first. After the last bit the data-out line is driven to 0.
- R5: The data-in line is sampled at the system clock edge where the scan clock rises. The first sampled bit lands in receive bit VEC_W-1 and the last in bit 0.
- R6: The receive vector is cleared when any operation is accepted, including one without a full scan.
- R7: The scan pulse counter rises by one for every scan clock pulse and the CPU pulse counter by one for every CPU clock pulse. Both are cleared only by reset.
- R8: busy is high from the cycle after the accepted start until the last slot ends. done is high for exactly one cycle, in the cycle busy falls. The operation lasts 2·Q·(2·preCPU + preScan + (1+2·VEC_W)·scan + 3·post) cycles from the start edge to done.
- R9: A start with all four flags clear gives done in the next cycle, never raises busy and toggles no pin.
- R10: A quarter-period input of 0 is treated as 1.
- R11: With busy low, the scan clock and CPU clock pins are low, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| pre_cpu_i | input | 1 | Enable the pre CPU pulse phase |
| pre_scan_i | input | 1 | Enable the single pre scan clock pulse |
| scan_i | input | 1 | Enable the full scan phase |
| post_cpu_i | input | 1 | Enable the post CPU pulse and trailing scan pulse |
| quarter_i | input | QW | Quarter-period in system cycles (0 acts as 1) |
| tx_vec_i | input | VEC_W | Vector to shift out, latched at start |
| rx_vec_o | output | VEC_W | Captured receive vector |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Scan clock pin |
| mosi_o | output | 1 | Scan data-out pin |
| miso_i | input | 1 | Scan data-in pin |
| cpu_clk_o | output | 1 | Target CPU clock pin |
| sclk_count_o | output | CNT_W | Scan clock pulse tally |
| cpu_count_o | output | CNT_W | CPU clock pulse tally |

## Verification
Every cycle, the assertions check that the pins hold still except at slot boundaries and that data-out only changes while the scan clock is low. They also check pin exclusivity and quiet pins when idle, the shape of the done pulse, the single-step growth of the counters and a nonzero latched quarter-period. Only the bench scenarios can show the order of pulses for a given flag set, the exact operation length, and the bit order of the vectors both ways. The same holds for clearing of the receive vector by an operation without a scan, and for the mapping of a zero quarter-period to one. The bench checks these with a behavioural target that captures data on scan clock rises and shifts its reply on scan clock falls.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PCPU_HI,
    ST_PCPU_LO,
    ST_PSCLK,
    ST_SETUP,
    ST_BIT_HI,
    ST_BIT_LO,
    ST_QCPU_HI,
    ST_QCPU_LO,
    ST_QSCLK
  } seq_state_e;

  typedef struct packed {
    logic post_cpu;
    logic scan;
    logic pre_sclk;
    logic pre_cpu;
  } phase_sel_t;

  // First enabled phase at or after position 'from' (0..3), IDLE if none.
  function automatic seq_state_e entry_from(input logic [2:0] from, input phase_sel_t sel);
    seq_state_e r;
    r = ST_IDLE;
    if (from <= 3'd3 && sel.post_cpu) r = ST_QCPU_HI;
    if (from <= 3'd2 && sel.scan)     r = ST_SETUP;
    if (from <= 3'd1 && sel.pre_sclk) r = ST_PSCLK;
    if (from == 3'd0 && sel.pre_cpu)  r = ST_PCPU_HI;
    return r;
  endfunction

  function automatic logic is_sclk_high(input seq_state_e s);
    return (s == ST_PSCLK) || (s == ST_BIT_HI) || (s == ST_QSCLK);
  endfunction

  function automatic logic is_cpu_high(input seq_state_e s);
    return (s == ST_PCPU_HI) || (s == ST_QCPU_HI);
  endfunction

endpackage

// File: rtl/dss_quarter_timer.sv
module dss_quarter_timer #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [QW-1:0] q_len_i,
  output logic          slot_end_o
);
  localparam logic [QW-1:0] ONE = QW'(1);

  logic [QW-1:0] cyc_q, cyc_d;
  logic          half_q, half_d;
  logic          q_last;

  assign q_last     = (cyc_q == (q_len_i - ONE));
  assign slot_end_o = run_i && q_last && half_q;

  always_comb begin
    cyc_d  = cyc_q;
    half_d = half_q;
    if (!run_i) begin
      cyc_d  = '0;
      half_d = 1'b0;
    end else if (q_last) begin
      cyc_d  = '0;
      half_d = ~half_q;
    end else begin
      cyc_d  = cyc_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      half_q <= half_d;
    end
  end

  assert_q_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (q_len_i != '0));

endmodule

// File: rtl/dss_phase_fsm.sv
module dss_phase_fsm
  import dss_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int QW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  phase_sel_t    sel_i,
  input  logic [QW-1:0] quarter_i,
  input  logic          slot_end_i,
  output logic          run_o,
  output logic [QW-1:0] q_len_o,
  output logic          accept_o,
  output logic          ev_setup_o,
  output logic          ev_sample_o,
  output logic          ev_advance_o,
  output logic          sclk_rise_o,
  output logic          cpu_rise_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          sclk_o,
  output logic          cpu_clk_o
);
  localparam int BIT_CW = (VEC_W > 1) ? $clog2(VEC_W) : 1;
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(VEC_W - 1);
  localparam logic [BIT_CW-1:0] BIT_ONE  = BIT_CW'(1);

  seq_state_e        state_q, state_d;
  phase_sel_t        sel_q, sel_d;
  logic [QW-1:0]     q_len_q, q_len_d;
  logic [BIT_CW-1:0] bit_q, bit_d;
  logic              busy_d, done_d, sclk_d, cpu_d;
  logic              enter;

  assign run_o    = (state_q != ST_IDLE);
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign q_len_o  = q_len_q;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    q_len_d = q_len_q;
    bit_d   = bit_q;
    if (accept_o) begin
      sel_d   = sel_i;
      q_len_d = (quarter_i == '0) ? QW'(1) : quarter_i;
      state_d = entry_from(3'd0, sel_i);
    end else if (slot_end_i) begin
      unique case (state_q)
        ST_PCPU_HI: state_d = ST_PCPU_LO;
        ST_PCPU_LO: state_d = entry_from(3'd1, sel_q);
        ST_PSCLK:   state_d = entry_from(3'd2, sel_q);
        ST_SETUP:   state_d = ST_BIT_HI;
        ST_BIT_HI:  state_d = ST_BIT_LO;
        ST_BIT_LO: begin
          if (bit_q == '0) begin
            state_d = entry_from(3'd3, sel_q);
          end else begin
            state_d = ST_BIT_HI;
            bit_d   = bit_q - BIT_ONE;
          end
        end
        ST_QCPU_HI: state_d = ST_QCPU_LO;
        ST_QCPU_LO: state_d = ST_QSCLK;
        ST_QSCLK:   state_d = ST_IDLE;
        default:    state_d = ST_IDLE;
      endcase
    end
    if (state_d == ST_SETUP && state_q != ST_SETUP) bit_d = LAST_BIT;
  end

  assign enter        = (state_d != state_q);
  assign ev_setup_o   = enter && (state_d == ST_SETUP);
  assign ev_sample_o  = enter && (state_d == ST_BIT_HI);
  assign ev_advance_o = enter && (state_d == ST_BIT_LO);
  assign sclk_rise_o  = enter && is_sclk_high(state_d);
  assign cpu_rise_o   = enter && is_cpu_high(state_d);

  assign busy_d = (state_d != ST_IDLE);
  assign done_d = (run_o || accept_o) && (state_d == ST_IDLE);
  assign sclk_d = is_sclk_high(state_d);
  assign cpu_d  = is_cpu_high(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      q_len_q   <= QW'(1);
      bit_q     <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      sclk_o    <= 1'b0;
      cpu_clk_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      sel_q     <= sel_d;
      q_len_q   <= q_len_d;
      bit_q     <= bit_d;
      busy_o    <= busy_d;
      done_o    <= done_d;
      sclk_o    <= sclk_d;
      cpu_clk_o <= cpu_d;
    end
  end

  assert_pins_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_o && cpu_clk_o));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !cpu_clk_o));
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_sclk_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !slot_end_i) |=> $stable(sclk_o));
  assert_cpu_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !slot_end_i) |=> $stable(cpu_clk_o));

endmodule

// File: rtl/dss_shift_path.sv
module dss_shift_path #(
  parameter int VEC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             ev_setup_i,
  input  logic             ev_sample_i,
  input  logic             ev_advance_i,
  input  logic [VEC_W-1:0] tx_vec_i,
  input  logic             miso_i,
  input  logic             sclk_i,
  output logic [VEC_W-1:0] rx_vec_o,
  output logic             mosi_o
);
  logic [VEC_W-1:0] tx_q, tx_d, rx_d;
  logic             mosi_d;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_vec_o;
    mosi_d = mosi_o;
    if (accept_i) begin
      tx_d = tx_vec_i;
      rx_d = '0;
    end
    if (ev_setup_i) mosi_d = accept_i ? tx_vec_i[VEC_W-1] : tx_q[VEC_W-1];
    if (ev_sample_i) rx_d = {rx_vec_o[VEC_W-2:0], miso_i};
    if (ev_advance_i) begin
      mosi_d = tx_q[VEC_W-2];
      tx_d   = {tx_q[VEC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_vec_o <= '0;
      mosi_o   <= 1'b0;
    end else begin
      tx_q     <= tx_d;
      rx_vec_o <= rx_d;
      mosi_o   <= mosi_d;
    end
  end

  assert_mosi_moves_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> !sclk_i);

endmodule

// File: rtl/dss_pulse_tally.sv
module dss_pulse_tally #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_d;

  assign count_d = inc_i ? count_o + CNT_W'(1) : count_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= count_d;
  end

  assert_tally_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + CNT_W'(1)));

endmodule

// File: rtl/dbg_scan_sequencer.sv
module dbg_scan_sequencer
  import dss_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int QW    = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pre_cpu_i,
  input  logic             pre_scan_i,
  input  logic             scan_i,
  input  logic             post_cpu_i,
  input  logic [QW-1:0]    quarter_i,
  input  logic [VEC_W-1:0] tx_vec_i,
  output logic [VEC_W-1:0] rx_vec_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             cpu_clk_o,
  output logic [CNT_W-1:0] sclk_count_o,
  output logic [CNT_W-1:0] cpu_count_o
);
  localparam int N_TALLY = 2;

  phase_sel_t    sel;
  logic          run, slot_end, accept;
  logic          ev_setup, ev_sample, ev_advance, sclk_rise, cpu_rise;
  logic [QW-1:0] q_len;
  logic [N_TALLY-1:0] tally_inc;
  logic [CNT_W-1:0]   tally_val [N_TALLY];

  assign sel.pre_cpu  = pre_cpu_i;
  assign sel.pre_sclk = pre_scan_i;
  assign sel.scan     = scan_i;
  assign sel.post_cpu = post_cpu_i;

  dss_quarter_timer #(.QW(QW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run), .q_len_i(q_len), .slot_end_o(slot_end)
  );

  dss_phase_fsm #(.VEC_W(VEC_W), .QW(QW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel),
    .quarter_i(quarter_i), .slot_end_i(slot_end), .run_o(run), .q_len_o(q_len),
    .accept_o(accept), .ev_setup_o(ev_setup), .ev_sample_o(ev_sample),
    .ev_advance_o(ev_advance), .sclk_rise_o(sclk_rise), .cpu_rise_o(cpu_rise),
    .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o), .cpu_clk_o(cpu_clk_o)
  );

  dss_shift_path #(.VEC_W(VEC_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .ev_setup_i(ev_setup),
    .ev_sample_i(ev_sample), .ev_advance_i(ev_advance), .tx_vec_i(tx_vec_i),
    .miso_i(miso_i), .sclk_i(sclk_o), .rx_vec_o(rx_vec_o), .mosi_o(mosi_o)
  );

  assign tally_inc = {cpu_rise, sclk_rise};

  for (genvar g = 0; g < N_TALLY; g++) begin : g_tally
    dss_pulse_tally #(.CNT_W(CNT_W)) u_tally (
      .clk(clk), .rst_n(rst_n), .inc_i(tally_inc[g]), .count_o(tally_val[g])
    );
  end

  assign sclk_count_o = tally_val[0];
  assign cpu_count_o  = tally_val[1];

endmodule

// File: tb/tb_dbg_scan_sequencer.sv
module tb_dbg_scan_sequencer;
  logic        clk, rst_n, start_i, miso_i;
  logic        pre_cpu_i, pre_scan_i, scan_i, post_cpu_i;
  logic [15:0] quarter_i;
  logic [63:0] tx_vec_i, rx_vec_o;
  logic        busy_o, done_o, sclk_o, mosi_o, cpu_clk_o;
  logic [31:0] sclk_count_o, cpu_count_o;

  int total = 0, bad = 0, cycles = 0;

  dbg_scan_sequencer dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural target: capture on rise, shift reply on fall
  logic [63:0] tgt, cap;
  assign miso_i = tgt[63];
  always @(posedge sclk_o) cap = {cap[62:0], mosi_o};
  always @(negedge sclk_o) tgt = {tgt[62:0], 1'b0};

  // per-operation measurements
  int          n_dur, nseq, wmin, wmax, run_s, run_c;
  logic [1:0]  seq [0:160];
  logic        busy_gap, mosi_first, done_after;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] f, input logic [15:0] q,
                        input logic [63:0] tx, input logic [63:0] tinit);
    logic ps, pc;
    tgt = tinit; cap = '0;
    nseq = 0; wmin = 100000; wmax = 0; run_s = 0; run_c = 0;
    busy_gap = 1'b0; ps = 1'b0; pc = 1'b0;
    @(negedge clk);
    {post_cpu_i, scan_i, pre_scan_i, pre_cpu_i} = f;
    quarter_i = q; tx_vec_i = tx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (k == 0) mosi_first = mosi_o;
      if (sclk_o && !ps) begin seq[nseq] = 2'd2; nseq++; end
      if (cpu_clk_o && !pc) begin seq[nseq] = 2'd1; nseq++; end
      if (sclk_o) run_s++;
      else if (ps) begin wmin = (run_s < wmin) ? run_s : wmin; wmax = (run_s > wmax) ? run_s : wmax; run_s = 0; end
      if (cpu_clk_o) run_c++;
      else if (pc) begin wmin = (run_c < wmin) ? run_c : wmin; wmax = (run_c > wmax) ? run_c : wmax; run_c = 0; end
      ps = sclk_o; pc = cpu_clk_o;
      if (done_o) begin
        n_dur = k;
        break;
      end
      if (!busy_o) busy_gap = 1'b1;
      @(negedge clk);
    end
    chk(!busy_o, "R8", "busy low at done", 64'(busy_o), 64'd0);
    @(negedge clk);
    done_after = done_o;
  endtask

  function automatic int exp_dur(input logic [3:0] f, input int qe);
    return 2 * qe * (2 * f[0] + f[1] + 129 * f[2] + 3 * f[3]);
  endfunction

  task automatic chk_seq(input logic [3:0] f, input string req);
    logic [1:0] e [0:160];
    int ne = 0, mism = 0;
    if (f[0]) begin e[ne] = 2'd1; ne++; end
    if (f[1]) begin e[ne] = 2'd2; ne++; end
    if (f[2]) for (int i = 0; i < 64; i++) begin e[ne] = 2'd2; ne++; end
    if (f[3]) begin e[ne] = 2'd1; ne++; e[ne] = 2'd2; ne++; end
    chk(nseq == ne, req, "pulse count", 64'(nseq), 64'(ne));
    for (int i = 0; i < ne && i < nseq; i++) if (seq[i] != e[i]) mism++;
    chk(mism == 0, req, "pulse order mismatches", 64'(mism), 64'd0);
  endtask

  task automatic test_reset();
    chk(!busy_o && !done_o, "R8", "idle after reset", {busy_o, done_o}, 64'd0);
    chk(!sclk_o && !cpu_clk_o && !mosi_o, "R11", "pins low after reset",
        {sclk_o, cpu_clk_o, mosi_o}, 64'd0);
    chk(sclk_count_o == 0 && cpu_count_o == 0, "R7", "tallies zero",
        {sclk_count_o, cpu_count_o}, 64'd0);
    chk(rx_vec_o == 0, "R6", "rx zero after reset", rx_vec_o, 64'd0);
  endtask

  task automatic test_empty();
    logic [31:0] s0, c0;
    s0 = sclk_count_o; c0 = cpu_count_o;
    run_op(4'b0000, 16'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    chk(n_dur == 0, "R9", "done delay", 64'(n_dur), 64'd0);
    chk(nseq == 0 && !busy_gap, "R9", "no pulses", 64'(nseq), 64'd0);
    chk(sclk_count_o == s0 && cpu_count_o == c0, "R9", "tallies unchanged",
        {sclk_count_o, cpu_count_o}, {s0, c0});
    chk(!done_after, "R8", "done one cycle", 64'(done_after), 64'd0);
  endtask

  task automatic test_scan_only();
    logic [63:0] tx = 64'hA5C3_0F1E_8000_7FF1, tg = 64'h1357_9BDF_F0E1_2C4B;
    logic [31:0] s0;
    s0 = sclk_count_o;
    run_op(4'b0100, 16'd1, tx, tg);
    chk(mosi_first == tx[63], "R4", "msb during setup", 64'(mosi_first), 64'(tx[63]));
    chk(cap == tx, "R4", "target captured", cap, tx);
    chk(rx_vec_o == tg, "R5", "rx vector", rx_vec_o, tg);
    chk(mosi_o == 1'b0, "R4", "mosi after last bit", 64'(mosi_o), 64'd0);
    chk(n_dur == exp_dur(4'b0100, 1), "R8", "scan duration", 64'(n_dur), 64'(exp_dur(4'b0100, 1)));
    chk(!busy_gap, "R8", "busy continuous", 64'(busy_gap), 64'd0);
    chk_seq(4'b0100, "R1");
    chk(sclk_count_o - s0 == 64, "R7", "scan tally", 64'(sclk_count_o - s0), 64'd64);
  endtask

  task automatic test_all_phases();
    logic [63:0] tx = 64'h0123_4567_89AB_CDEF, tg = 64'hFEDC_BA98_7654_3211;
    logic [31:0] s0, c0;
    s0 = sclk_count_o; c0 = cpu_count_o;
    run_op(4'b1111, 16'd3, tx, tg);
    chk_seq(4'b1111, "R1");
    chk(nseq >= 2 && seq[nseq-2] == 2'd1 && seq[nseq-1] == 2'd2, "R3",
        "post cpu then sclk", {seq[nseq-2], seq[nseq-1]}, 64'h6);
    chk(wmin == 6 && wmax == 6, "R2", "pulse widths", {32'(wmin), 32'(wmax)}, {32'd6, 32'd6});
    chk(n_dur == exp_dur(4'b1111, 3), "R8", "full duration", 64'(n_dur), 64'(exp_dur(4'b1111, 3)));
    chk(rx_vec_o == {tg[62:0], 1'b0}, "R5", "rx after pre pulse", rx_vec_o, {tg[62:0], 1'b0});
    chk(cap == {tx[62:0], 1'b0}, "R4", "target capture", cap, {tx[62:0], 1'b0});
    chk(sclk_count_o - s0 == 66, "R7", "sclk tally", 64'(sclk_count_o - s0), 64'd66);
    chk(cpu_count_o - c0 == 2, "R7", "cpu tally", 64'(cpu_count_o - c0), 64'd2);
  endtask

  task automatic test_rx_clear();
    chk(rx_vec_o != 0, "R6", "rx nonzero before", rx_vec_o, 64'd1);
    run_op(4'b0001, 16'd2, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(rx_vec_o == 0, "R6", "rx cleared", rx_vec_o, 64'd0);
    chk(wmin == 4 && wmax == 4, "R2", "cpu width", {32'(wmin), 32'(wmax)}, {32'd4, 32'd4});
    chk(n_dur == 8, "R2", "cpu pulse period", 64'(n_dur), 64'd8);
  endtask

  task automatic test_zero_quarter();
    run_op(4'b1001, 16'd0, 64'd0, 64'd0);
    chk(n_dur == exp_dur(4'b1001, 1), "R10", "duration with q=0", 64'(n_dur),
        64'(exp_dur(4'b1001, 1)));
    chk(wmin == 2 && wmax == 2, "R10", "width with q=0", {32'(wmin), 32'(wmax)}, {32'd2, 32'd2});
    chk_seq(4'b1001, "R1");
  endtask

  task automatic test_pre_post_sclk();
    run_op(4'b1010, 16'd2, 64'd0, 64'd0);
    chk_seq(4'b1010, "R1");
    chk(n_dur == exp_dur(4'b1010, 2), "R3", "duration", 64'(n_dur), 64'(exp_dur(4'b1010, 2)));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; quarter_i = 16'd1; tx_vec_i = '0;
    {post_cpu_i, scan_i, pre_scan_i, pre_cpu_i} = 4'b0000;
    tgt = '0; cap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_empty();
    test_scan_only();
    test_all_phases();
    test_rx_clear();
    test_zero_quarter();
    test_pre_post_sclk();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule